// File: doc/BRIEF.md
# Microprogrammed Instruction Cycle Sequencer

This block is the control unit of a small accumulator-style processor, built as a microprogrammed controller. A control store holds microinstructions. Each one carries a set of register-transfer strobes, a condition selector and a branch target. A microprogram counter walks the control store through four groups of microinstructions: instruction fetch, indirect operand resolution, execute, and the interrupt check. Each group occupies a contiguous range of control-store addresses. The block owns the program counter, the memory address register, the data register and the instruction register. It talks to a synchronous main memory outside the block through a read strobe and an address.

An instruction word has a 4-bit operation code in its top bits and an indirect flag directly below it. Its low bits hold an address. Opcode 1 is branch-on-zero. Its microroutine tests the ALU zero flag, which comes from outside the block, and microbranches to a taken or a not-taken routine. Opcode 2 is a jump through memory. Every other opcode only advances the program counter. After each instruction the sequencer checks for a pending, enabled interrupt. If it finds one, it acknowledges it and redirects the program counter to a fixed vector before the next fetch.

Top module: `microcode_sequencer`

## Requirements
- R1: While `rst_n` is low, `pc`, `ir`, `upc` and `not_taken` are zero and `mem_rd` and `irq_ack` are low.
- R2: Fetch reads memory at the current `pc`. `mem_rd` is high for one cycle and `ld_dr` follows in the next cycle. `pc` increases by one and the word is loaded into `ir`. An instruction with no indirect step and no operand read makes exactly one memory read.
- R3: When bit 11 of the instruction (the indirect flag) is 1, the sequencer makes one extra memory read at the address field. The low 8 bits of the word it reads replace the address field before execute.
- R4: Opcode 2 (bits 15:12) reads memory at the address field and loads the low 8 bits of that word into `pc`.
- R5: Opcode 1 with `zero_flag` high at its test loads the address field into `pc` and clears `not_taken`.
- R6: Opcode 1 with `zero_flag` low leaves `pc` at the incremented value and sets `not_taken`.
- R7: Any other opcode leaves `pc` at the incremented value and leaves `not_taken` unchanged.
- R8: If `irq_req` and `irq_en` are both high at the interrupt check, `irq_ack` pulses for one cycle and `pc` becomes `IRQ_VEC` (default 0xF0) before the next fetch. If `irq_en` is low, `irq_req` has no effect.
- R9: An instruction takes 4 fetch cycles, 4 more when indirect, then 3 (branch taken), 4 (branch not taken), 6 (opcode 2) or 2 (other) execute cycles, then 2 interrupt-check cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| zero_flag | input | 1 | Zero result of the last ALU operation |
| irq_req | input | 1 | Interrupt request |
| irq_en | input | 1 | Interrupt enable |
| mem_rdata | input | 16 | Memory read data, valid the cycle after `mem_rd` |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 8 | Memory address (memory address register) |
| ld_pc | output | 1 | Program counter load strobe |
| ld_mar | output | 1 | Address register load strobe |
| ld_dr | output | 1 | Data register load strobe |
| ld_ir | output | 1 | Instruction register load strobe |
| irq_ack | output | 1 | Interrupt acknowledge pulse |
| pc | output | 8 | Program counter |
| ir | output | 16 | Instruction register |
| upc | output | 5 | Microprogram counter |
| not_taken | output | 1 | Set by an untaken branch-on-zero, cleared by a taken one |

## Verification
The hardest case to reach is an interrupt that arrives after a taken branch that was itself fetched indirectly. Reaching it needs a program whose control flow reaches the indirect branch with the zero flag high and the request raised at the same time. The bench walks a fixed program that chains both branch outcomes, both addressing modes and the jump through memory. It changes `zero_flag`, `irq_req` and `irq_en` only at instruction boundaries, so every combination lands on a known instruction. That includes an enabled interrupt on top of a taken branch and a request while interrupts are disabled.

// File: rtl/useq_pkg.sv
// Package: microinstruction format and control-store contents.
// Assumes a 5-bit microaddress and an instruction word with a 4-bit opcode on top.
package useq_pkg;

    localparam int UA_W    = 5;
    localparam int U_DEPTH = 21;

    localparam logic [3:0] OP_BZ  = 4'h1;
    localparam logic [3:0] OP_JMM = 4'h2;

    typedef enum logic [2:0] {
        C_SEQ    = 3'd0,  // never branch
        C_JMP    = 3'd1,  // always branch
        C_ZERO   = 3'd2,  // zero flag set
        C_IRQ    = 3'd3,  // enabled request pending
        C_DIRECT = 3'd4,  // fetched word has indirect flag clear
        C_OPBZ   = 3'd5,  // opcode is branch-on-zero
        C_NOTJMM = 3'd6   // opcode is not jump-through-memory
    } cond_e;

    typedef struct packed {
        logic mar_pc;
        logic mar_ir;
        logic rd;
        logic dr_ld;
        logic ir_ld;
        logic ira_ld;
        logic pc_inc;
        logic pc_dr;
        logic pc_ir;
        logic pc_vec;
        logic nt_set;
        logic nt_clr;
        logic ack;
        cond_e cond;
        logic [UA_W-1:0] nxt;
    } uinst_t;

    // Microaddresses of the routine entry points
    localparam logic [UA_W-1:0] UA_FETCH = 5'd0;
    localparam logic [UA_W-1:0] UA_EXEC  = 5'd8;
    localparam logic [UA_W-1:0] UA_ZERO  = 5'd16;
    localparam logic [UA_W-1:0] UA_NZERO = 5'd17;
    localparam logic [UA_W-1:0] UA_ICHK  = 5'd18;
    localparam logic [UA_W-1:0] UA_IACK  = 5'd20;

    // Control-store contents, grouped: fetch 0-3, indirect 4-7, execute 8-17, interrupt 18-20
    function automatic uinst_t ucode(input logic [UA_W-1:0] a);
        uinst_t u;
        u      = '0;
        u.cond = C_SEQ;
        case (a)
            5'd0:  u.mar_pc = 1'b1;
            5'd1:  begin u.rd = 1'b1; u.pc_inc = 1'b1; end
            5'd2:  u.dr_ld = 1'b1;
            5'd3:  begin u.ir_ld = 1'b1; u.cond = C_DIRECT; u.nxt = UA_EXEC; end
            5'd4:  u.mar_ir = 1'b1;
            5'd5:  u.rd = 1'b1;
            5'd6:  u.dr_ld = 1'b1;
            5'd7:  u.ira_ld = 1'b1;
            5'd8:  begin u.cond = C_OPBZ; u.nxt = 5'd14; end
            5'd9:  begin u.cond = C_NOTJMM; u.nxt = UA_ICHK; end
            5'd10: u.mar_ir = 1'b1;
            5'd11: u.rd = 1'b1;
            5'd12: u.dr_ld = 1'b1;
            5'd13: begin u.pc_dr = 1'b1; u.cond = C_JMP; u.nxt = UA_ICHK; end
            5'd14: begin u.cond = C_ZERO; u.nxt = UA_ZERO; end
            5'd15: begin u.cond = C_JMP; u.nxt = UA_NZERO; end
            5'd16: begin u.pc_ir = 1'b1; u.nt_clr = 1'b1; u.cond = C_JMP; u.nxt = UA_ICHK; end
            5'd17: begin u.nt_set = 1'b1; u.cond = C_JMP; u.nxt = UA_ICHK; end
            5'd18: begin u.cond = C_IRQ; u.nxt = UA_IACK; end
            5'd19: begin u.cond = C_JMP; u.nxt = UA_FETCH; end
            5'd20: begin u.ack = 1'b1; u.pc_vec = 1'b1; u.cond = C_JMP; u.nxt = UA_FETCH; end
            default: begin u.cond = C_JMP; u.nxt = UA_FETCH; end
        endcase
        return u;
    endfunction

endpackage

// File: rtl/useq_store.sv
// Control store: maps the microprogram counter to the current microinstruction.
// Assumes the contents are fixed at build time (read-only, combinational read).
module useq_store
    import useq_pkg::*;
(
    input  logic [UA_W-1:0] addr,
    output uinst_t          uinst
);
    // Combinational read of the fixed microprogram
    always_comb uinst = ucode(addr);
endmodule

// File: rtl/useq_next.sv
// Microprogram counter with condition selection.
// Assumes a true condition takes the branch target, a false one steps by one.
module useq_next
    import useq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cond_e             cond,
    input  logic [UA_W-1:0]   target,
    input  logic              zero_flag,
    input  logic              irq_pend,
    input  logic [DATA_W-1:0] dr,
    input  logic [DATA_W-1:0] ir,
    output logic [UA_W-1:0]   upc
);
    localparam int OP_HI  = DATA_W - 1;
    localparam int IND_B  = DATA_W - 5;

    logic take;

    // Evaluate the selected branch condition
    always_comb begin
        case (cond)
            C_JMP:    take = 1'b1;
            C_ZERO:   take = zero_flag;
            C_IRQ:    take = irq_pend;
            C_DIRECT: take = ~dr[IND_B];
            C_OPBZ:   take = (ir[OP_HI -: 4] == OP_BZ);
            C_NOTJMM: take = (ir[OP_HI -: 4] != OP_JMM);
            default:  take = 1'b0;
        endcase
    end

    // Advance or branch the microprogram counter
    always_ff @(posedge clk) begin
        if (!rst_n)    upc <= '0;
        else if (take) upc <= target;
        else           upc <= upc + 1'b1;
    end
endmodule

// File: rtl/useq_regs.sv
// Architectural registers PC, MAR, DR, IR and the not-taken flag.
// Assumes at most one PC source is active per microinstruction.
module useq_regs
    import useq_pkg::*;
#(
    parameter int                ADDR_W  = 8,
    parameter int                DATA_W  = 16,
    parameter logic [ADDR_W-1:0] IRQ_VEC = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  uinst_t            u,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] mar,
    output logic [DATA_W-1:0] dr,
    output logic [DATA_W-1:0] ir,
    output logic              not_taken
);
    // Program counter: increment, jump from DR, branch from IR or vector
    always_ff @(posedge clk) begin
        if (!rst_n)        pc <= '0;
        else if (u.pc_vec) pc <= IRQ_VEC;
        else if (u.pc_ir)  pc <= ir[ADDR_W-1:0];
        else if (u.pc_dr)  pc <= dr[ADDR_W-1:0];
        else if (u.pc_inc) pc <= pc + 1'b1;
    end

    // Memory address register: from PC or IR address field
    always_ff @(posedge clk) begin
        if (!rst_n)        mar <= '0;
        else if (u.mar_pc) mar <= pc;
        else if (u.mar_ir) mar <= ir[ADDR_W-1:0];
    end

    // Data register: captures memory data one cycle after the read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)       dr <= '0;
        else if (u.dr_ld) dr <= mem_rdata;
    end

    // Instruction register: full load or address-field replacement
    always_ff @(posedge clk) begin
        if (!rst_n)        ir <= '0;
        else if (u.ir_ld)  ir <= dr;
        else if (u.ira_ld) ir[ADDR_W-1:0] <= dr[ADDR_W-1:0];
    end

    // Branch-not-taken status
    always_ff @(posedge clk) begin
        if (!rst_n)        not_taken <= 1'b0;
        else if (u.nt_set) not_taken <= 1'b1;
        else if (u.nt_clr) not_taken <= 1'b0;
    end
endmodule

// File: rtl/microcode_sequencer.sv
// Top: microprogrammed instruction cycle sequencer.
// Assumes a synchronous memory returning data the cycle after mem_rd.
module microcode_sequencer
    import useq_pkg::*;
#(
    parameter int                ADDR_W  = 8,
    parameter int                DATA_W  = 16,
    parameter logic [ADDR_W-1:0] IRQ_VEC = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              zero_flag,
    input  logic              irq_req,
    input  logic              irq_en,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              ld_pc,
    output logic              ld_mar,
    output logic              ld_dr,
    output logic              ld_ir,
    output logic              irq_ack,
    output logic [ADDR_W-1:0] pc,
    output logic [DATA_W-1:0] ir,
    output logic [UA_W-1:0]   upc,
    output logic              not_taken
);
    uinst_t            u;
    logic [DATA_W-1:0] dr;

    useq_store u_store (.addr(upc), .uinst(u));

    useq_next #(.DATA_W(DATA_W)) u_next (
        .clk(clk), .rst_n(rst_n), .cond(u.cond), .target(u.nxt),
        .zero_flag(zero_flag), .irq_pend(irq_req & irq_en),
        .dr(dr), .ir(ir), .upc(upc)
    );

    useq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IRQ_VEC(IRQ_VEC)) u_regs (
        .clk(clk), .rst_n(rst_n), .u(u), .mem_rdata(mem_rdata),
        .pc(pc), .mar(mem_addr), .dr(dr), .ir(ir), .not_taken(not_taken)
    );

    // Strobe outputs gathered from microinstruction fields
    always_comb begin
        mem_rd  = u.rd & rst_n;
        ld_mar  = u.mar_pc | u.mar_ir;
        ld_dr   = u.dr_ld;
        ld_ir   = u.ir_ld | u.ira_ld;
        ld_pc   = u.pc_inc | u.pc_dr | u.pc_ir | u.pc_vec;
        irq_ack = u.ack & rst_n;
    end
endmodule

// File: rtl/useq_chk.sv
// Checker: protocol and ordering properties at the sequencer's ports.
module useq_chk #(
    parameter int                ADDR_W  = 8,
    parameter int                DATA_W  = 16,
    parameter logic [ADDR_W-1:0] IRQ_VEC = 8'hF0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_req,
    input logic              irq_en,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              ld_dr,
    input logic              irq_ack,
    input logic [ADDR_W-1:0] pc,
    input logic [DATA_W-1:0] ir,
    input logic [4:0]        upc,
    input logic              not_taken
);
    a_r2_rd_then_dr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> ld_dr);
    a_r2_fetch_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == 5'd0) |=> (mem_rd && mem_addr == $past(pc)));
    a_r8_ack_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> $past(irq_req && irq_en));
    a_r8_ack_vector: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> (pc == IRQ_VEC && upc == 5'd0));
    a_r6_nt_rise_bz: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(not_taken) |-> (ir[DATA_W-1 -: 4] == 4'h1));
    a_r9_upc_range: assert property (@(posedge clk) disable iff (!rst_n)
        upc <= 5'd20);
endmodule

bind microcode_sequencer useq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IRQ_VEC(IRQ_VEC)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .ld_dr(ld_dr), .irq_ack(irq_ack),
    .pc(pc), .ir(ir), .upc(upc), .not_taken(not_taken)
);

// File: tb/tb_microcode_sequencer.sv
module tb_microcode_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        zero_flag = 1'b0, irq_req = 1'b0, irq_en = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        mem_rd, ld_pc, ld_mar, ld_dr, ld_ir, irq_ack, not_taken;
    logic [7:0]  mem_addr, pc;
    logic [15:0] ir;
    logic [4:0]  upc;
    logic [15:0] mem [256];

    int tests = 0, fails = 0;

    microcode_sequencer dut (
        .clk(clk), .rst_n(rst_n), .zero_flag(zero_flag), .irq_req(irq_req),
        .irq_en(irq_en), .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .ld_pc(ld_pc), .ld_mar(ld_mar), .ld_dr(ld_dr), .ld_ir(ld_ir),
        .irq_ack(irq_ack), .pc(pc), .ir(ir), .upc(upc), .not_taken(not_taken)
    );

    always #2.5 clk = ~clk;

    // Synchronous memory model
    always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int e_pc, e_nt, e_acks, acks;
        bit zpat[12], rpat[12], epat[12];
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        mem[8'h00] = 16'h1010; mem[8'h10] = 16'h1020; mem[8'h11] = 16'h2040;
        mem[8'h30] = 16'h1841; mem[8'h50] = 16'h3000; mem[8'h51] = 16'h3000;
        mem[8'hF0] = 16'h2842; mem[8'h60] = 16'h1841; mem[8'h62] = 16'h1070;
        mem[8'h40] = 16'h0030; mem[8'h41] = 16'h0050; mem[8'h42] = 16'h0043;
        mem[8'h43] = 16'h0060;
        zpat = '{1,0,0,1,0,0,0,0,0,1,0,1};
        rpat = '{0,0,0,0,1,1,0,0,0,1,0,0};
        epat = '{0,0,0,0,0,1,0,0,1,1,0,0};

        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 pc", pc, 0); check("R1 upc", upc, 0); check("R1 ir", ir, 0);
        check("R1 not_taken", not_taken, 0); check("R1 mem_rd", mem_rd, 0);
        check("R1 irq_ack", irq_ack, 0);
        rst_n = 1'b1;
        e_pc = 0; e_nt = 0; e_acks = 0; acks = 0;

        for (int s = 0; s < 12; s++) begin
            int inst, op, a, e_rd, e_cyc, cyc, rds;
            string tg;
            bit ind;
            zero_flag = zpat[s]; irq_req = rpat[s]; irq_en = epat[s];
            // Reference model for one instruction
            inst = mem[e_pc]; op = inst[15:12]; ind = inst[11]; a = inst[7:0];
            e_pc = (e_pc + 1) & 8'hFF; e_rd = 1; e_cyc = 6;
            if (ind) begin a = mem[a] & 8'hFF; e_rd++; e_cyc += 4; end
            if (op == 1) begin
                if (zpat[s]) begin e_pc = a; e_nt = 0; e_cyc += 3; tg = "R5"; end
                else begin e_nt = 1; e_cyc += 4; tg = "R6"; end
            end else if (op == 2) begin
                e_pc = mem[a] & 8'hFF; e_rd++; e_cyc += 6; tg = "R4";
            end else begin
                e_cyc += 2; tg = "R7";
            end
            if (ind) tg = {tg, "/R3"};
            if (rpat[s] && epat[s]) begin e_pc = 8'hF0; e_acks++; end
            // Run the design to the next instruction boundary
            cyc = 0; rds = 0;
            do begin
                if (mem_rd) rds++;
                if (irq_ack) acks++;
                @(negedge clk);
                cyc++;
            end while (upc != 0 && cyc < 100);
            check($sformatf("%s pc step %0d", tg, s), pc, e_pc);
            check($sformatf("%s not_taken step %0d", tg, s), not_taken, e_nt);
            check($sformatf("R8 acks step %0d", s), acks, e_acks);
            check($sformatf("R9 cycles step %0d", s), cyc, e_cyc);
            check($sformatf("R2 reads step %0d", s), rds, e_rd);
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule